// File: doc/BRIEF.md
# Mantissa Rounding Stage

This block takes a working mantissa whose two lowest bits are the guard and round positions, together with a separate sticky bit, the operand sign and a two-bit rounding mode. It removes the guard and round positions, decides whether one unit must be added at the new least significant position, and returns the result one clock after the operand is presented. The decision follows one of four modes: nearest with ties to even, toward zero, toward plus infinity and toward minus infinity.

Three flags come with each result. The inexact flag reports that guard, round or sticky was nonzero. The rounded-up flag and the fraction-rounded flag both report that an increment was applied. The block does not renormalize. The result is one bit wider than the shifted mantissa, so an increment that carries out of the top bit shows up in the extra top bit. Exponent adjustment, special values and final packing belong to the consumer.

Top module: `rnd_unit`

## Requirements
- R1: While rst_n is low and after its release until the first accepted operand, out_valid, mant_out, rnd_up, inexact and frac_rnd are all zero.
- R2: An operand presented with in_valid high at a rising edge produces its result and out_valid high after that edge. Cycles with in_valid low drop out_valid and leave mant_out and the three flags unchanged.
- R3: Guard is mant_in[1] and round is mant_in[0]. When guard, round and sticky_in are all zero, mant_out equals mant_in shifted right by two with a zero top bit, and all three flags are low.
- R4: inexact is high exactly when at least one of guard, round and sticky_in is high.
- R5: Mode 2'b00 (nearest, ties to even) increments only when guard is high and at least one of round, sticky_in and bit 0 of the shifted mantissa (mant_in[2]) is high.
- R6: Mode 2'b01 (toward zero) never increments.
- R7: Mode 2'b10 (toward plus infinity) increments exactly when the result is inexact and sign_in is 0 (positive).
- R8: Mode 2'b11 (toward minus infinity) increments exactly when the result is inexact and sign_in is 1 (negative).
- R9: On an increment, mant_out equals the shifted mantissa plus one with the carry rippling through every bit, and rnd_up and frac_rnd are both high; without an increment both are low.
- R10: When the shifted mantissa is all ones and an increment happens, mant_out has only its top bit set (no renormalization).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| mant_in | input | MANT_W | Mantissa; bit 1 guard, bit 0 round |
| sticky_in | input | 1 | OR of all bits below round |
| sign_in | input | 1 | Operand sign, 1 = negative |
| mode_in | input | 2 | Rounding mode (see R5 to R8) |
| out_valid | output | 1 | Result present |
| mant_out | output | MANT_W-1 | Rounded mantissa with carry-out bit on top |
| rnd_up | output | 1 | Increment was applied |
| inexact | output | 1 | Guard, round or sticky was nonzero |
| frac_rnd | output | 1 | Fraction was rounded up |

## Verification
Every piece of state in this block is the output register, so a wrong decision or a broken carry bit appears on mant_out or the flags in the very cycle after the operand is accepted, and a stale register appears as a held value that does not follow a new operand. The bench sweeps all guard, round, sticky, sign and mode combinations over odd and even mantissas, so a mistaken tie rule or a swapped sign test shows on the first offending operand. The all-ones mantissa exposes a truncated carry chain or a dropped carry-out bit immediately.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_POS  = 2'b10,
    RM_NEG  = 2'b11
  } rnd_mode_e;

  typedef struct packed {
    logic inc;
    logic inx;
  } rnd_dec_t;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic      guard_i,
  input  logic      round_i,
  input  logic      sticky_i,
  input  logic      lsb_i,
  input  logic      sign_i,
  input  logic [1:0] mode_i,
  output rnd_dec_t  dec_o
);
  logic lost;

  always_comb begin
    lost      = guard_i | round_i | sticky_i;
    dec_o.inx = lost;
    unique case (rnd_mode_e'(mode_i))
      RM_NEAR: dec_o.inc = guard_i & (round_i | sticky_i | lsb_i);
      RM_ZERO: dec_o.inc = 1'b0;
      RM_POS:  dec_o.inc = lost & ~sign_i;
      RM_NEG:  dec_o.inc = lost &  sign_i;
      default: dec_o.inc = 1'b0;
    endcase
  end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int unsigned WIDTH = 10
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             inc_i,
  output logic [WIDTH:0]   sum_o
);
  logic [WIDTH:0] carry;

  assign carry[0] = inc_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign sum_o[i]   = val_i[i] ^ carry[i];
    assign carry[i+1] = val_i[i] & carry[i];
  end

  assign sum_o[WIDTH] = carry[WIDTH];
endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
  import rnd_pkg::*;
#(
  parameter int unsigned MANT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MANT_W-1:0] mant_in,
  input  logic              sticky_in,
  input  logic              sign_in,
  input  logic [1:0]        mode_in,
  output logic              out_valid,
  output logic [MANT_W-2:0] mant_out,
  output logic              rnd_up,
  output logic              inexact,
  output logic              frac_rnd
);
  localparam int unsigned SH_W  = MANT_W - 2;
  localparam int unsigned OUT_W = SH_W + 1;

  logic [SH_W-1:0]  shifted;
  rnd_dec_t         dec;
  logic [OUT_W-1:0] sum;

  assign shifted = mant_in[MANT_W-1:2];

  rnd_decide u_dec (
    .guard_i  (mant_in[1]),
    .round_i  (mant_in[0]),
    .sticky_i (sticky_in),
    .lsb_i    (shifted[0]),
    .sign_i   (sign_in),
    .mode_i   (mode_in),
    .dec_o    (dec)
  );

  rnd_incr #(.WIDTH(SH_W)) u_inc (
    .val_i (shifted),
    .inc_i (dec.inc),
    .sum_o (sum)
  );

  // next-state
  logic             vld_d, up_d, inx_d, fr_d;
  logic [OUT_W-1:0] mant_d;

  always_comb begin
    vld_d  = in_valid;
    mant_d = mant_out;
    up_d   = rnd_up;
    inx_d  = inexact;
    fr_d   = frac_rnd;
    if (in_valid) begin
      mant_d = sum;
      up_d   = dec.inc;
      inx_d  = dec.inx;
      fr_d   = dec.inc;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mant_out  <= '0;
      rnd_up    <= 1'b0;
      inexact   <= 1'b0;
      frac_rnd  <= 1'b0;
    end else begin
      out_valid <= vld_d;
      mant_out  <= mant_d;
      rnd_up    <= up_d;
      inexact   <= inx_d;
      frac_rnd  <= fr_d;
    end
  end
endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk #(
  parameter int unsigned MANT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [MANT_W-1:0] mant_in,
  input logic              sticky_in,
  input logic              sign_in,
  input logic [1:0]        mode_in,
  input logic              out_valid,
  input logic [MANT_W-2:0] mant_out,
  input logic              rnd_up,
  input logic              inexact,
  input logic              frac_rnd
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(mant_out) && $stable(rnd_up) && $stable(inexact)));

  a_r4_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (inexact == $past(|{mant_in[1:0], sticky_in})));

  a_r3_exact_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !inexact) |-> (!rnd_up && !frac_rnd));

  a_r5_near_no_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_in == 2'b00 && !mant_in[1]) |=> !rnd_up);

  a_r6_zero_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_in == 2'b01) |=> !rnd_up);

  a_r7_pos_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_in == 2'b10) |=> (rnd_up == (inexact && !$past(sign_in))));

  a_r8_neg_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_in == 2'b11) |=> (rnd_up == (inexact && $past(sign_in))));

  a_r9_flags_agree: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rnd_up == frac_rnd));

  a_r9_sum: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (mant_out == ({1'b0, $past(mant_in[MANT_W-1:2])} + (MANT_W-1)'(rnd_up))));
endmodule

bind rnd_unit rnd_unit_chk #(.MANT_W(MANT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .mant_in   (mant_in),
  .sticky_in (sticky_in),
  .sign_in   (sign_in),
  .mode_in   (mode_in),
  .out_valid (out_valid),
  .mant_out  (mant_out),
  .rnd_up    (rnd_up),
  .inexact   (inexact),
  .frac_rnd  (frac_rnd)
);

// File: tb/rnd_unit_test.sv
module rnd_unit_test;
  localparam int W  = 12;
  localparam int SW = W - 2;
  localparam int OW = W - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  mant_in;
  logic          sticky_in;
  logic          sign_in;
  logic [1:0]    mode_in;
  logic          out_valid;
  logic [OW-1:0] mant_out;
  logic          rnd_up, inexact, frac_rnd;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  rnd_unit #(.MANT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mant_in(mant_in),
    .sticky_in(sticky_in), .sign_in(sign_in), .mode_in(mode_in),
    .out_valid(out_valid), .mant_out(mant_out), .rnd_up(rnd_up),
    .inexact(inexact), .frac_rnd(frac_rnd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic want_up(logic [W-1:0] m, logic s, logic sg, logic [1:0] md);
    logic g, r, lost;
    g = m[1]; r = m[0]; lost = g | r | s;
    case (md)
      2'b00:   return g & (r | s | m[2]);
      2'b01:   return 1'b0;
      2'b10:   return lost & ~sg;
      default: return lost & sg;
    endcase
  endfunction

  // apply one operand and check all outputs after the capturing edge
  task automatic apply(input string req, input logic [W-1:0] m, input logic s,
                       input logic sg, input logic [1:0] md);
    logic up;
    logic [OW-1:0] exp_m;
    @(negedge clk);
    mant_in = m; sticky_in = s; sign_in = sg; mode_in = md; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    up    = want_up(m, s, sg, md);
    exp_m = {1'b0, m[W-1:2]} + OW'(up);
    check({req, " mant"},  32'(mant_out), 32'(exp_m));
    check({req, " up"},    32'(rnd_up),   32'(up));
    check({req, " fr"},    32'(frac_rnd), 32'(up));
    check({req, " inx"},   32'(inexact),  32'(|{m[1:0], s}));
    check({req, " valid"}, 32'(out_valid), 32'd1);
  endtask

  task automatic t_reset;
    in_valid = 1'b0; mant_in = '1; sticky_in = 1'b1; sign_in = 1'b1; mode_in = 2'b10;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(out_valid), 0);
    check("R1 mant in reset",  32'(mant_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", 32'(out_valid), 0);
    check("R1 flags after release", 32'({rnd_up, inexact, frac_rnd}), 0);
    check("R1 mant after release",  32'(mant_out), 0);
  endtask

  task automatic t_exact;
    apply("R3 exact odd",  {10'h2B5, 2'b00}, 1'b0, 1'b0, 2'b10);
    apply("R3 exact even", {10'h1A4, 2'b00}, 1'b0, 1'b1, 2'b00);
    check("R3 pass value", 32'(mant_out), 32'h1A4);
  endtask

  task automatic t_nearest;
    apply("R5 tie even stays", {10'h0A4, 2'b10}, 1'b0, 1'b0, 2'b00);
    check("R5 tie even value", 32'(mant_out), 32'h0A4);
    apply("R5 tie odd bumps",  {10'h0A5, 2'b10}, 1'b0, 1'b0, 2'b00);
    check("R5 tie odd value", 32'(mant_out), 32'h0A6);
    apply("R5 above half", {10'h0A4, 2'b10}, 1'b1, 1'b0, 2'b00);
    apply("R5 below half", {10'h0A5, 2'b01}, 1'b1, 1'b1, 2'b00);
    check("R5 below half no up", 32'(rnd_up), 0);
  endtask

  task automatic t_zero;
    apply("R6 toward zero", {10'h3FE, 2'b11}, 1'b1, 1'b0, 2'b01);
    check("R6 no up", 32'(rnd_up), 0);
  endtask

  task automatic t_dir;
    apply("R7 plus pos", {10'h100, 2'b00}, 1'b1, 1'b0, 2'b10);
    check("R7 plus pos up", 32'(rnd_up), 1);
    apply("R7 plus neg", {10'h100, 2'b01}, 1'b0, 1'b1, 2'b10);
    check("R7 plus neg no up", 32'(rnd_up), 0);
    apply("R8 minus neg", {10'h100, 2'b00}, 1'b1, 1'b1, 2'b11);
    check("R8 minus neg up", 32'(rnd_up), 1);
    apply("R8 minus pos", {10'h100, 2'b10}, 1'b0, 1'b0, 2'b11);
    check("R8 minus pos no up", 32'(rnd_up), 0);
  endtask

  task automatic t_carry;
    apply("R9 ripple", {10'h0FF, 2'b11}, 1'b0, 1'b0, 2'b00);
    check("R9 ripple value", 32'(mant_out), 32'h100);
    apply("R10 carry out", {10'h3FF, 2'b10}, 1'b0, 1'b0, 2'b00);
    check("R10 top bit only", 32'(mant_out), 32'h400);
    apply("R10 carry out minus", {10'h3FF, 2'b00}, 1'b1, 1'b1, 2'b11);
    check("R10 top bit minus", 32'(mant_out), 32'h400);
  endtask

  task automatic t_hold;
    logic [OW-1:0] prev;
    apply("R2 load", {10'h155, 2'b11}, 1'b0, 1'b0, 2'b10);
    prev = mant_out;
    @(negedge clk);
    mant_in = '0; sticky_in = 1'b1; mode_in = 2'b00;
    repeat (2) @(negedge clk);
    check("R2 valid drops", 32'(out_valid), 0);
    check("R2 mant held",   32'(mant_out), 32'(prev));
    check("R2 flags held",  32'({rnd_up, inexact, frac_rnd}), 32'b111);
  endtask

  task automatic t_sweep;
    for (int md = 0; md < 4; md++)
      for (int gr = 0; gr < 4; gr++)
        for (int s = 0; s < 2; s++)
          for (int sg = 0; sg < 2; sg++)
            for (int b = 0; b < 2; b++) begin
              logic [SW-1:0] base;
              base = (b == 0) ? 10'h155 : 10'h2AA;
              apply((md == 0) ? "R5 sweep" : (md == 1) ? "R6 sweep" :
                    (md == 2) ? "R7 sweep" : "R8 sweep",
                    {base, 2'(gr)}, 1'(s), 1'(sg), 2'(md));
            end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_exact();
    t_nearest();
    t_zero();
    t_dir();
    t_carry();
    t_hold();
    t_sweep();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule